// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Shared Timebases

This block generates eight pulse-width-modulated outputs from four shared period counters. Each counter has its own programmable period. Each channel picks one of the four counters through a 2-bit source select. Channels on different timebases can therefore run at different frequencies, while channels on the same timebase stay phase-aligned. Each channel compares its active duty value with the count of its chosen timebase and drives a registered output.

Software programs the periods, duty values, source selects, a global run bit and a per-channel pin mode through a plain synchronous write port. A registered read port returns what was written. A new duty value is staged and only takes effect when the chosen counter wraps, so a period is never cut short or glitched. A channel whose pin is in GPIO-input mode releases its pad: its enable output goes low and its data output is held low.

A single tick-enable input paces all counters, and it stands in for any prescaler.

Top module: `pwm_bank`

## Requirements
- R1: Synchronous active-high reset clears all counters, all duty values (staged and active), both source-select registers and the control register. It sets every period to 200 and every pin-mode register to 0x80. During reset and in the cycle after it, `pwm_out`, `pwm_oe` and `rd_data` are 0.
- R2: A write at `wr_addr` with `wr_en` high stores `wr_data` at the next clock edge. The address map is: period of timebase t at 0x00+t (t = 0..3), duty of channel c at 0x08+c, select group low at 0x10, select group high at 0x11, control at 0x12, and pin mode of channel c at 0x18+c. `rd_data` returns the content at `rd_addr` one cycle later. Reading a duty address returns the staged value, and an unmapped address reads 0.
- R3: Each timebase counts 0, 1, …, period, then 0 again. It advances only in a cycle where `tick` is high and bit 1 of the control register is set, and holds otherwise. If its count is already at or above a newly written period, it returns to 0 at its next advance.
- R4: Channel c uses the 2-bit field at bits [(c mod 4)·2 +: 2] of the low select group (channels 0–3) or the high select group (channels 4–7). The field value selects timebase 0..3.
- R5: With a nonzero active duty below the chosen period, `pwm_out[c]` is high in the cycle after one in which the chosen count is below the active duty. It is low otherwise, so it is high for `duty` cycles out of every `period+1` advances.
- R6: An active duty of 0 holds the output low. A nonzero active duty equal to or above the chosen period holds the output high for the whole period.
- R7: A written duty value becomes active at the next wrap of the channel's chosen timebase, and not before. A duty written in the same cycle as that wrap becomes active only at the following wrap.
- R8: A pin-mode register with bit 7 set puts the channel in GPIO-input mode: `pwm_oe[c]` and `pwm_out[c]` are 0 from the next cycle. With bit 7 clear, `pwm_oe[c]` is 1 and the channel drives its PWM level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler tick enable for all timebases |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after `rd_addr` |
| pwm_out | output | 8 | Per-channel PWM level, low in GPIO-input mode |
| pwm_oe | output | 8 | Per-channel pad drive enable |

## Verification
The critical coincidence is a duty write that lands in the same cycle as a wrap of the channel's chosen timebase. It also matters when a period or source-select write lands at that moment. The wrap must load the previously staged value, and the new write must wait for the following wrap. This is provoked in a long random phase with short periods, a mostly-high tick and frequent duty, period and select writes, so many writes fall on wrap cycles. Every cycle is judged against a bench model that applies wraps from the pre-write state before it takes the write.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ADDR_W = 5;

  // register map
  localparam logic [ADDR_W-1:0] A_PERIOD = 5'h00;
  localparam logic [ADDR_W-1:0] A_DUTY   = 5'h08;
  localparam logic [ADDR_W-1:0] A_SEL    = 5'h10;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h12;
  localparam logic [ADDR_W-1:0] A_PIN    = 5'h18;

  localparam int RUN_BIT      = 1;
  localparam int PIN_GPIO_BIT = 7;
  localparam logic [7:0] PIN_RST = 8'h80;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_TB     = 4,
  parameter int DATA_W     = 8,
  parameter int PERIOD_RST = 200,
  parameter int SEL_W      = $clog2(NUM_TB)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [NUM_TB-1:0][DATA_W-1:0]     period,
  output logic [NUM_CH-1:0][DATA_W-1:0]     duty,
  output logic [NUM_CH*SEL_W-1:0]           sel_flat,
  output logic                              run,
  output logic [NUM_CH-1:0]                 pin_gpio
);
  localparam int CH_PER_GRP = DATA_W / SEL_W;
  localparam int NUM_GRP    = (NUM_CH + CH_PER_GRP - 1) / CH_PER_GRP;
  localparam int SEL_BITS   = NUM_GRP * DATA_W;

  logic [SEL_BITS-1:0]               sel_q;
  logic [DATA_W-1:0]                 ctrl_q;
  logic [NUM_CH-1:0][DATA_W-1:0]     pin_q;
  logic [DATA_W-1:0]                 rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TB; t++) period[t] <= DATA_W'(PERIOD_RST);
      for (int c = 0; c < NUM_CH; c++) begin
        duty[c]  <= '0;
        pin_q[c] <= DATA_W'(PIN_RST);
      end
      sel_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int t = 0; t < NUM_TB; t++)
        if (wr_addr == A_PERIOD + ADDR_W'(t)) period[t] <= wr_data;
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == A_DUTY + ADDR_W'(c)) duty[c]  <= wr_data;
        if (wr_addr == A_PIN + ADDR_W'(c))  pin_q[c] <= wr_data;
      end
      for (int g = 0; g < NUM_GRP; g++)
        if (wr_addr == A_SEL + ADDR_W'(g)) sel_q[g*DATA_W +: DATA_W] <= wr_data;
      if (wr_addr == A_CTRL) ctrl_q <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < NUM_TB; t++)
      if (rd_addr == A_PERIOD + ADDR_W'(t)) rd_mux = period[t];
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == A_DUTY + ADDR_W'(c)) rd_mux = duty[c];
      if (rd_addr == A_PIN + ADDR_W'(c))  rd_mux = pin_q[c];
    end
    for (int g = 0; g < NUM_GRP; g++)
      if (rd_addr == A_SEL + ADDR_W'(g)) rd_mux = sel_q[g*DATA_W +: DATA_W];
    if (rd_addr == A_CTRL) rd_mux = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign sel_flat = sel_q[NUM_CH*SEL_W-1:0];
  assign run      = ctrl_q[RUN_BIT];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
      assign pin_gpio[c] = pin_q[c][PIN_GPIO_BIT];
    end
  endgenerate
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // wrap on reaching (or having passed) the period, so a lowered period recovers at once
  assign wrap = adv && (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (adv)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int NUM_TB = 4,
  parameter int W      = 8,
  parameter int SEL_W  = $clog2(NUM_TB)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEL_W-1:0]           sel,
  input  logic [NUM_TB-1:0][W-1:0]   cnt_all,
  input  logic [NUM_TB-1:0][W-1:0]   period_all,
  input  logic [NUM_TB-1:0]          wrap_all,
  input  logic [W-1:0]               duty_staged,
  input  logic                       gpio_mode,
  output logic                       out_q,
  output logic                       oe_q
);
  logic [W-1:0] duty_act;
  logic [W-1:0] cnt_s;
  logic [W-1:0] per_s;
  logic         wrap_s;
  logic         level;

  assign cnt_s  = cnt_all[sel];
  assign per_s  = period_all[sel];
  assign wrap_s = wrap_all[sel];

  always_ff @(posedge clk) begin
    if (rst)         duty_act <= '0;
    else if (wrap_s) duty_act <= duty_staged;
  end

  always_comb begin
    if (duty_act == '0)         level = 1'b0;
    else if (duty_act >= per_s) level = 1'b1;
    else                        level = (cnt_s < duty_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= !gpio_mode && level;
      oe_q  <= !gpio_mode;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_TB     = 4,
  parameter int DATA_W     = 8,
  parameter int PERIOD_RST = 200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_CH-1:0]   pwm_out,
  output logic [NUM_CH-1:0]   pwm_oe
);
  localparam int SEL_W = $clog2(NUM_TB);

  logic [NUM_TB-1:0][DATA_W-1:0] period;
  logic [NUM_CH-1:0][DATA_W-1:0] duty;
  logic [NUM_CH*SEL_W-1:0]       sel_flat;
  logic                          run;
  logic [NUM_CH-1:0]             pin_gpio;
  logic [NUM_TB-1:0][DATA_W-1:0] cnt_all;
  logic [NUM_TB-1:0]             wrap_all;
  logic                          adv;

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .NUM_TB(NUM_TB), .DATA_W(DATA_W),
    .PERIOD_RST(PERIOD_RST), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .period(period), .duty(duty), .sel_flat(sel_flat),
    .run(run), .pin_gpio(pin_gpio)
  );

  assign adv = run && tick;

  generate
    for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
      pwm_bank_timebase #(.W(DATA_W)) u_tb (
        .clk(clk), .rst(rst), .adv(adv), .period(period[t]),
        .cnt(cnt_all[t]), .wrap(wrap_all[t])
      );
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_bank_chan #(.NUM_TB(NUM_TB), .W(DATA_W), .SEL_W(SEL_W)) u_ch (
        .clk(clk), .rst(rst),
        .sel(sel_flat[c*SEL_W +: SEL_W]),
        .cnt_all(cnt_all), .period_all(period), .wrap_all(wrap_all),
        .duty_staged(duty[c]), .gpio_mode(pin_gpio[c]),
        .out_q(pwm_out[c]), .oe_q(pwm_oe[c])
      );
    end
  endgenerate
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int NUM_TB = 4,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          tick,
  input logic                          run,
  input logic [NUM_TB-1:0][DATA_W-1:0] cnt_all,
  input logic [NUM_TB-1:0]             wrap_all,
  input logic [NUM_CH-1:0]             pin_gpio,
  input logic [NUM_CH-1:0]             pwm_out,
  input logic [NUM_CH-1:0]             pwm_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pwm_out == '0 && pwm_oe == '0)); // R1

  generate
    for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(run && tick) |=> $stable(cnt_all[t])); // R3
      AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !wrap_all[t]) |=> cnt_all[t] == $past(cnt_all[t]) + DATA_W'(1)); // R3
      AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_all[t] |=> cnt_all[t] == '0); // R3
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_GPIO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        pin_gpio[c] |=> (!pwm_oe[c] && !pwm_out[c])); // R8
      AST_PWM_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !pin_gpio[c] |=> pwm_oe[c]); // R8
    end
  endgenerate
endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .NUM_TB(NUM_TB), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run),
  .cnt_all(cnt_all), .wrap_all(wrap_all), .pin_gpio(pin_gpio),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 8;
  localparam int NTB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] pwm_oe;

  always #5 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- reference model (from the requirements) ----------------
  int m_per[NTB];
  int m_cnt[NTB];
  int m_duty[NCH];
  int m_act[NCH];
  int m_pin[NCH];
  int m_sel;
  int m_ctrl;
  bit m_w[NTB];
  bit m_adv;
  logic [NCH-1:0] e_out = '0;
  logic [NCH-1:0] e_oe = '0;
  int e_rd = 0;
  bit mon_on = 1'b0;

  function automatic int sel_of(int c);
    return (m_sel >> (c * 2)) & 3;
  endfunction

  function automatic int mread(int a);
    if (a < NTB) return m_per[a];
    if (a >= 8 && a < 16) return m_duty[a-8];
    if (a == 16) return m_sel & 255;
    if (a == 17) return (m_sel >> 8) & 255;
    if (a == 18) return m_ctrl;
    if (a >= 24) return m_pin[a-24];
    return 0;
  endfunction

  function automatic bit level_of(int c);
    int s;
    s = sel_of(c);
    if (m_act[c] == 0) return 1'b0;
    if (m_act[c] >= m_per[s]) return 1'b1;
    return m_cnt[s] < m_act[c];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTB; t++) begin m_per[t] = 200; m_cnt[t] = 0; end
      for (int c = 0; c < NCH; c++) begin m_duty[c] = 0; m_act[c] = 0; m_pin[c] = 8'h80; end
      m_sel = 0; m_ctrl = 0;
      e_out = '0; e_oe = '0; e_rd = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        e_oe[c]  = (m_pin[c] & 8'h80) == 0;
        e_out[c] = e_oe[c] && level_of(c);
      end
      e_rd = mread(int'(rd_addr));
      m_adv = ((m_ctrl >> 1) & 1) == 1 && tick;
      for (int t = 0; t < NTB; t++) m_w[t] = m_adv && (m_cnt[t] >= m_per[t]);
      for (int c = 0; c < NCH; c++) if (m_w[sel_of(c)]) m_act[c] = m_duty[c];
      for (int t = 0; t < NTB; t++)
        m_cnt[t] = m_w[t] ? 0 : (m_adv ? m_cnt[t] + 1 : m_cnt[t]);
      if (wr_en) begin
        if (wr_addr < NTB) m_per[wr_addr] = wr_data;
        else if (wr_addr >= 8 && wr_addr < 16) m_duty[wr_addr-8] = wr_data;
        else if (wr_addr == 16) m_sel = (m_sel & 16'hFF00) | wr_data;
        else if (wr_addr == 17) m_sel = (m_sel & 16'h00FF) | (int'(wr_data) << 8);
        else if (wr_addr == 18) m_ctrl = wr_data;
        else if (wr_addr >= 24) m_pin[wr_addr-24] = wr_data;
      end
    end
  end

  // every cycle: outputs against the model (duty/wrap coincidences land here)
  always @(negedge clk) begin
    if (mon_on) begin
      chk(pwm_out === e_out, "R5/R6/R7 pwm_out vs model", int'(pwm_out), int'(e_out));
      chk(pwm_oe === e_oe, "R8 pwm_oe vs model", int'(pwm_oe), int'(e_oe));
      chk(rd_data === 8'(e_rd), "R2 rd_data vs model", int'(rd_data), e_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic count_high(input int n, output int hi[NCH], output int oe_hi[NCH]);
    for (int c = 0; c < NCH; c++) begin hi[c] = 0; oe_hi[c] = 0; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pwm_out[c]) hi[c]++;
        if (pwm_oe[c]) oe_hi[c]++;
      end
    end
  endtask

  task automatic hold_check(input int n, input string req);
    logic [NCH-1:0] snap;
    bit same;
    snap = pwm_out;
    same = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== snap) same = 1'b0;
    end
    chk(same, req, int'(pwm_out), int'(snap));
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int d;
    int hi[NCH];
    int oe_hi[NCH];
    int exp_hi[NCH];
    void'($urandom(32'h1357));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;

    // R1: reset state
    chk(pwm_out == '0 && pwm_oe == '0, "R1 outputs after reset", int'(pwm_out), 0);
    rd(8'h18, d); chk(d == 8'h80, "R1 pin mode reset", d, 8'h80);
    rd(8'h00, d); chk(d == 200, "R1 period reset", d, 200);
    rd(8'h0B, d); chk(d == 0, "R1 duty reset", d, 0);
    rd(8'h12, d); chk(d == 0, "R1 control reset", d, 0);

    // R2: write/readback, unmapped address
    wr(8'h01, 8'h5A); rd(8'h01, d); chk(d == 8'h5A, "R2 period readback", d, 8'h5A);
    wr(8'h11, 8'hE4); rd(8'h11, d); chk(d == 8'hE4, "R2 select-high readback", d, 8'hE4);
    rd(8'h07, d); chk(d == 0, "R2 unmapped reads 0", d, 0);

    // steady configuration for R4/R5/R6/R8
    tick = 1'b1;
    wr(0, 9); wr(1, 4); wr(2, 3); wr(3, 7);
    wr(8'h10, 8'hD8);  // ch0->tb0 ch1->tb2 ch2->tb1 ch3->tb3
    wr(8'h11, 8'hE1);  // ch4->tb1 ch5->tb0 ch6->tb2 ch7->tb3
    wr(8'h08, 3); wr(8'h09, 2); wr(8'h0A, 0); wr(8'h0B, 7);
    wr(8'h0C, 1); wr(8'h0D, 12); wr(8'h0E, 3); wr(8'h0F, 5);
    for (int c = 0; c < 7; c++) wr(8'h18 + c, 0);
    wr(8'h1F, 8'h80);
    wr(8'h12, 8'h02);
    repeat (30) @(negedge clk);
    count_high(40, hi, oe_hi);
    exp_hi = '{12, 20, 0, 40, 8, 40, 40, 0};
    chk(hi[0] == exp_hi[0], "R5 ch0 duty 3 of 10", hi[0], exp_hi[0]);
    chk(hi[1] == exp_hi[1], "R4 ch1 on timebase 2", hi[1], exp_hi[1]);
    chk(hi[2] == exp_hi[2], "R6 duty zero low", hi[2], exp_hi[2]);
    chk(hi[3] == exp_hi[3], "R6 duty equal period high", hi[3], exp_hi[3]);
    chk(hi[4] == exp_hi[4], "R4 ch4 on timebase 1", hi[4], exp_hi[4]);
    chk(hi[5] == exp_hi[5], "R6 duty above period high", hi[5], exp_hi[5]);
    chk(hi[6] == exp_hi[6], "R4 ch6 on timebase 2 full", hi[6], exp_hi[6]);
    chk(hi[7] == 0 && oe_hi[7] == 0, "R8 gpio channel released", oe_hi[7], 0);
    chk(oe_hi[0] == 40, "R8 pwm channel drives", oe_hi[0], 40);

    // R3: tick low freezes, then run bit low freezes
    tick = 1'b0;
    repeat (2) @(negedge clk);
    hold_check(12, "R3 frozen without tick");
    tick = 1'b1;
    wr(8'h12, 8'h00);
    repeat (2) @(negedge clk);
    hold_check(12, "R3 frozen with run bit clear");

    // R7: staged duty has no effect until a wrap
    wr(8'h08, 8);
    rd(8'h08, d); chk(d == 8, "R7 staged duty readback", d, 8);
    hold_check(12, "R7 no effect before wrap");
    wr(8'h12, 8'h02);
    repeat (25) @(negedge clk);
    count_high(10, hi, oe_hi);
    chk(hi[0] == 8, "R7 new duty after wrap", hi[0], 8);

    // random phase: writes frequently coincide with wraps
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick = ($urandom % 5) != 0;
      rd_addr = 5'($urandom % 32);
      wr_en = 1'b0;
      rst = (i == 1500);
      if ($urandom % 3 == 0) begin
        int k;
        k = $urandom % 6;
        wr_en = 1'b1;
        case (k)
          0: begin wr_addr = 5'($urandom % 4); wr_data = 8'($urandom % 13); end
          1, 2: begin wr_addr = 5'(8 + $urandom % 8); wr_data = 8'($urandom % 16); end
          3: begin wr_addr = 5'(16 + $urandom % 2); wr_data = 8'($urandom); end
          4: begin wr_addr = 5'd18; wr_data = ($urandom % 8 == 0) ? 8'h00 : 8'h02; end
          default: begin
            wr_addr = 5'(24 + $urandom % 8);
            wr_data = ($urandom % 4 == 0) ? 8'h80 : (($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
          end
        endcase
      end
    end
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b0;
    repeat (5) @(negedge clk);
    report();
  end
endmodule